// File: doc/BRIEF.md
# Indirect-Access GPIO Bank

This block provides 22 general-purpose pins split into three groups of 8, 6 and 8. Software never addresses a pin's data directly. It writes a group number into an index port, then reads or writes that group's data byte through a companion data port. The two ports live at a pair of I/O addresses chosen by a selection byte. The same byte also decides whether the pair responds at all.

Each pin has its own configuration byte on a separate configuration bus. That byte sets the direction, an optional polarity inversion, and whether the pad is driven from the pin's data bit or from an alternate-function signal supplied by another peripheral. A read of a group returns the live pad level for input pins and the stored value for output pins. This lets software change one output pin with a read-modify-write of its group byte without disturbing the other pins.

Top module: `gpio_indirect_bank`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all zero), the port pair is disabled, and `io_rdata` is 0xFF.
- R2: The selection byte is written at configuration address 0x03. Bit 7 enables the port pair, and bits 1:0 pick the index/data addresses: 0 gives 0xE0/0xE1, 1 gives 0xE2/0xE3, 2 gives 0xE4/0xE5, 3 gives 0xEA/0xEB. Other I/O addresses do not respond.
- R3: While bit 7 of the selection byte is clear, I/O writes are ignored and every I/O read returns 0xFF.
- R4: A write to the index port stores the byte, and a read of the index port returns it. `io_rdata` is valid in the cycle after `io_rd` and holds 0xFF in every cycle that follows no responding read.
- R5: A data-port write with index 1, 2 or 3 updates only the stored bits of group A (pins 0–7), B (pins 8–13) or C (pins 14–21) respectively. The other groups are unchanged.
- R6: A read of group B returns its six pins in bits 5:0, with bits 7:6 as zero. Written bits 7:6 are discarded.
- R7: Bit 0 of a pin's configuration byte set makes the pin an input (`pad_oe` low). When it is clear, the pin drives its pad.
- R8: Bit 1 set inverts the pin. An output drives the stored bit inverted, and an input reads back the pad level inverted. Reading an output pin always returns its stored bit.
- R9: Bit 3 set makes an output pin drive its `alt_out` bit instead of the stored bit.
- R10: Configuration bytes for group A are at 0xE0+n, for group B at 0xE8+n, and for group C at 0xF5+n, where n is the pin's position within its group. Other configuration addresses, and bits 2 and 7:4 of a configuration byte, have no effect.
- R11: With an index other than 1, 2 or 3, data-port reads return 0x00 and data-port writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| pad_in | input | 22 | Pad levels seen by the pins |
| alt_out | input | 22 | Alternate-function output values |
| pad_out | output | 22 | Pad output values |
| pad_oe | output | 22 | Pad output enables |

## Verification
The assertions assume three things about the inputs:
- `io_rd` and `io_wr` do not target the index and data ports in the same cycle.
- Reads are single-cycle strobes.
- `pad_in` and `alt_out` change only while no read of the affected group is in flight.

The stimulus drives every strobe for exactly one cycle and changes pad and alternate inputs only between transactions. Every expected read value therefore follows from the register state alone.

// File: rtl/gib_pkg.sv
package gib_pkg;

  typedef struct packed {
    logic special;
    logic invert;
    logic is_input;
  } pin_cfg_t;

  localparam pin_cfg_t PIN_CFG_RESET = '{special: 1'b0, invert: 1'b0, is_input: 1'b1};

  function automatic logic [7:0] pair_base(input logic [1:0] code);
    case (code)
      2'd0:    return 8'hE0;
      2'd1:    return 8'hE2;
      2'd2:    return 8'hE4;
      default: return 8'hEA;
    endcase
  endfunction

endpackage

// File: rtl/gib_port_decode.sv
module gib_port_decode #(
  parameter int AW = 8
) (
  input  logic          enable,
  input  logic [1:0]    code,
  input  logic [AW-1:0] addr,
  output logic          idx_hit,
  output logic          dat_hit
);
  logic [AW-1:0] base;

  always_comb begin
    base    = AW'(gib_pkg::pair_base(code));
    idx_hit = enable && (addr == base);
    dat_hit = enable && (addr == base + AW'(1));
  end
endmodule

// File: rtl/gib_pin_cell.sv
module gib_pin_cell #(
  parameter logic [7:0] CFG_ADDR = 8'hE0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_addr,
  input  gib_pkg::pin_cfg_t cfg_new,
  input  logic             lat_bit,
  input  logic             alt_bit,
  input  logic             pad_in_bit,
  output logic             pad_out_bit,
  output logic             pad_oe_bit,
  output logic             rd_bit
);
  gib_pkg::pin_cfg_t cfg_q;
  logic cfg_hit;

  assign cfg_hit = cfg_wr && (cfg_addr == CFG_ADDR);

  always_ff @(posedge clk) begin
    if (rst)          cfg_q <= gib_pkg::PIN_CFG_RESET;
    else if (cfg_hit) cfg_q <= cfg_new;
  end

  always_comb begin
    pad_oe_bit  = !cfg_q.is_input;
    pad_out_bit = cfg_q.special ? alt_bit : (lat_bit ^ cfg_q.invert);
    rd_bit      = cfg_q.is_input ? (pad_in_bit ^ cfg_q.invert) : lat_bit;
  end

  // R7: a configuration write that selects input releases the pad on the next cycle
  assert_input_releases_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_hit && cfg_new.is_input) |=> !pad_oe_bit);

  // R9: a special output pin follows the alternate source once configured
  assert_special_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_hit && cfg_new.special && !cfg_new.is_input) |=> (pad_oe_bit && pad_out_bit == alt_bit));
endmodule

// File: rtl/gpio_indirect_bank.sv
module gpio_indirect_bank #(
  parameter int         GA       = 8,
  parameter int         GB       = 6,
  parameter int         GC       = 8,
  parameter int         DW       = 8,
  parameter logic [7:0] SEL_ADDR = 8'h03,
  parameter logic [7:0] A_CFG    = 8'hE0,
  parameter logic [7:0] B_CFG    = 8'hE8,
  parameter logic [7:0] C_CFG    = 8'hF5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic [7:0]          cfg_addr,
  input  logic [7:0]          cfg_wdata,
  input  logic [DW-1:0]       io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [DW-1:0]       io_wdata,
  output logic [DW-1:0]       io_rdata,
  input  logic [GA+GB+GC-1:0] pad_in,
  input  logic [GA+GB+GC-1:0] alt_out,
  output logic [GA+GB+GC-1:0] pad_out,
  output logic [GA+GB+GC-1:0] pad_oe
);
  localparam int NP    = GA + GB + GC;
  localparam int B_LO  = GA;
  localparam int C_LO  = GA + GB;
  localparam logic [DW-1:0] IDX_A = DW'(1);
  localparam logic [DW-1:0] IDX_B = DW'(2);
  localparam logic [DW-1:0] IDX_C = DW'(3);

  logic          sel_en_q;
  logic [1:0]    sel_code_q;
  logic [DW-1:0] index_q;
  logic [NP-1:0] lat_q;
  logic [NP-1:0] rd_bits;
  logic [DW-1:0] grp_val;
  logic [DW-1:0] rdata_q;
  logic          idx_hit, dat_hit;
  gib_pkg::pin_cfg_t cfg_new;
  logic          unused_cfg_bits;

  assign cfg_new = '{special: cfg_wdata[3], invert: cfg_wdata[1], is_input: cfg_wdata[0]};
  assign unused_cfg_bits = ^{cfg_wdata[6:4], cfg_wdata[2]};

  // selection byte
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_en_q   <= 1'b0;
      sel_code_q <= 2'd0;
    end else if (cfg_wr && cfg_addr == SEL_ADDR) begin
      sel_en_q   <= cfg_wdata[7];
      sel_code_q <= cfg_wdata[1:0];
    end
  end

  gib_port_decode #(.AW(DW)) u_decode (
    .enable (sel_en_q),
    .code   (sel_code_q),
    .addr   (io_addr),
    .idx_hit(idx_hit),
    .dat_hit(dat_hit)
  );

  // index register and group data latches
  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      lat_q   <= '0;
    end else if (io_wr) begin
      if (idx_hit) index_q <= io_wdata;
      if (dat_hit) begin
        case (index_q)
          IDX_A:   lat_q[B_LO-1:0]  <= io_wdata[GA-1:0];
          IDX_B:   lat_q[C_LO-1:B_LO] <= io_wdata[GB-1:0];
          IDX_C:   lat_q[NP-1:C_LO] <= io_wdata[GC-1:0];
          default: ;
        endcase
      end
    end
  end

  // per-pin configuration and pad logic
  for (genvar i = 0; i < NP; i++) begin : g_pin
    localparam logic [7:0] CA = (i < B_LO) ? 8'(A_CFG + i) :
                                (i < C_LO) ? 8'(B_CFG + (i - B_LO)) :
                                             8'(C_CFG + (i - C_LO));
    gib_pin_cell #(.CFG_ADDR(CA)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .cfg_wr     (cfg_wr),
      .cfg_addr   (cfg_addr),
      .cfg_new    (cfg_new),
      .lat_bit    (lat_q[i]),
      .alt_bit    (alt_out[i]),
      .pad_in_bit (pad_in[i]),
      .pad_out_bit(pad_out[i]),
      .pad_oe_bit (pad_oe[i]),
      .rd_bit     (rd_bits[i])
    );
  end

  always_comb begin
    grp_val = '0;
    case (index_q)
      IDX_A:   grp_val[GA-1:0] = rd_bits[B_LO-1:0];
      IDX_B:   grp_val[GB-1:0] = rd_bits[C_LO-1:B_LO];
      IDX_C:   grp_val[GC-1:0] = rd_bits[NP-1:C_LO];
      default: grp_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata_q <= '1;
    else if (io_rd && idx_hit) rdata_q <= index_q;
    else if (io_rd && dat_hit) rdata_q <= grp_val;
    else                      rdata_q <= '1;
  end

  assign io_rdata = rdata_q;

  // R1: the first cycle out of reset sees every pad released
  assert_reset_inputs_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && io_rdata == '1));

  // R3: a read while the pair is disabled yields all ones
  assert_disabled_read_R3: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !sel_en_q) |=> io_rdata == '1);

  // R4: an index-port read returns the index held when it was issued
  assert_index_readback_R4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && idx_hit) |=> io_rdata == $past(index_q));

  // R5: a write to group A leaves groups B and C untouched
  assert_group_isolation_R5: assert property (@(posedge clk) disable iff (rst)
    (io_wr && dat_hit && index_q == IDX_A) |=> $stable(lat_q[NP-1:B_LO]));

  // R6: group B reads carry zeros above its pin count
  assert_groupb_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (io_rd && dat_hit && index_q == IDX_B) |=> (io_rdata >> GB) == '0);
endmodule

// File: tb/gpio_indirect_bank_bench.sv
module gpio_indirect_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0;
  logic [7:0]  io_addr = '0, io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [21:0] pad_in = '0, alt_out = '0;
  logic [21:0] pad_out, pad_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  gpio_indirect_bank u_gpio_indirect_bank (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .pad_in(pad_in), .alt_out(alt_out),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(pad_oe == 22'h0, "R1 pads released", 32'(pad_oe), 32'h0);
    check(io_rdata == 8'hFF, "R1 idle rdata", 32'(io_rdata), 32'hFF);
    io_read(8'hE0, d);
    check(d == 8'hFF, "R3 disabled index read", 32'(d), 32'hFF);
    io_read(8'hEB, d);
    check(d == 8'hFF, "R3 disabled data read", 32'(d), 32'hFF);
  endtask

  task automatic t_disabled_write();
    io_write(8'hE0, 8'h01);
    io_write(8'hE1, 8'h55);
    for (int i = 0; i < 8; i++) cfg_write(8'hE0 + 8'(i), 8'h00);
    check(pad_oe[7:0] == 8'hFF, "R7 group A outputs", 32'(pad_oe[7:0]), 32'hFF);
    check(pad_out[7:0] == 8'h00, "R3 disabled write ignored", 32'(pad_out[7:0]), 32'h00);
  endtask

  task automatic t_select();
    logic [7:0] bases [4] = '{8'hE0, 8'hE2, 8'hE4, 8'hEA};
    logic [7:0] d;
    for (int k = 0; k < 4; k++) begin
      cfg_write(8'h03, 8'h80 | 8'(k));
      io_write(bases[k], 8'(k + 1));
      io_read(bases[k], d);
      check(d == 8'(k + 1), "R2 R4 index readback", 32'(d), 32'(k + 1));
      io_read(bases[(k + 1) % 4], d);
      check(d == 8'hFF, "R2 other pair silent", 32'(d), 32'hFF);
    end
    io_write(8'hEA, 8'h01);
  endtask

  task automatic t_data_rmw();
    logic [7:0] d;
    io_write(8'hEB, 8'hA5);
    check(pad_out[7:0] == 8'hA5, "R5 group A drive", 32'(pad_out[7:0]), 32'hA5);
    for (int i = 0; i < 8; i++) cfg_write(8'hF5 + 8'(i), 8'h00);
    io_write(8'hEA, 8'h03);
    io_write(8'hEB, 8'h3C);
    check(pad_out[21:14] == 8'h3C, "R5 group C drive", 32'(pad_out[21:14]), 32'h3C);
    check(pad_out[7:0] == 8'hA5, "R5 group A kept", 32'(pad_out[7:0]), 32'hA5);
    io_write(8'hEA, 8'h01);
    io_read(8'hEB, d);
    check(d == 8'hA5, "R5 group A readback", 32'(d), 32'hA5);
  endtask

  task automatic t_group_b();
    logic [7:0] d;
    for (int i = 0; i < 6; i++) cfg_write(8'hE8 + 8'(i), 8'h00);
    io_write(8'hEA, 8'h02);
    io_write(8'hEB, 8'hFF);
    check(pad_out[13:8] == 6'h3F, "R6 group B drive", 32'(pad_out[13:8]), 32'h3F);
    io_read(8'hEB, d);
    check(d == 8'h3F, "R6 group B upper bits zero", 32'(d), 32'h3F);
  endtask

  task automatic t_input_read();
    logic [7:0] d;
    pad_in[3] = 1'b1;
    cfg_write(8'hE3, 8'h01);
    io_write(8'hEA, 8'h01);
    check(pad_oe[3] == 1'b0, "R7 input releases pad", 32'(pad_oe[3]), 32'h0);
    io_read(8'hEB, d);
    check(d == 8'hAD, "R7 input reads pad", 32'(d), 32'hAD);
    cfg_write(8'hE3, 8'h03);
    io_read(8'hEB, d);
    check(d == 8'hA5, "R8 inverted input read", 32'(d), 32'hA5);
  endtask

  task automatic t_polarity_out();
    logic [7:0] d;
    cfg_write(8'hE0, 8'h02);
    check(pad_out[0] == 1'b0, "R8 inverted output drive", 32'(pad_out[0]), 32'h0);
    io_read(8'hEB, d);
    check(d == 8'hA5, "R8 output reads stored bit", 32'(d), 32'hA5);
  endtask

  task automatic t_special();
    alt_out[14] = 1'b1;
    cfg_write(8'hF5, 8'h08);
    check(pad_out[14] == 1'b1 && pad_oe[14], "R9 alternate high", 32'(pad_out[14]), 32'h1);
    @(negedge clk);
    alt_out[14] = 1'b0;
    @(negedge clk);
    check(pad_out[14] == 1'b0, "R9 alternate low", 32'(pad_out[14]), 32'h0);
  endtask

  task automatic t_cfg_addr();
    cfg_write(8'hF4, 8'h01);
    cfg_write(8'hEE, 8'h01);
    cfg_write(8'hFD, 8'h01);
    check(pad_oe == 22'h3FFFF7, "R10 stray addresses ignored", 32'(pad_oe), 32'h3FFFF7);
    cfg_write(8'hFC, 8'h01);
    check(pad_oe == 22'h1FFFF7, "R10 last group C pin", 32'(pad_oe), 32'h1FFFF7);
    cfg_write(8'hE8, 8'h02);
    check(pad_out[8] == 1'b0, "R10 group B pin 0 inverted", 32'(pad_out[8]), 32'h0);
    cfg_write(8'hE8, 8'hF4);
    check(pad_out[8] == 1'b1 && pad_oe[8], "R10 unused bits ignored", 32'(pad_out[8]), 32'h1);
  endtask

  task automatic t_bad_index();
    logic [7:0] d;
    logic [21:0] snap;
    snap = pad_out;
    io_write(8'hEA, 8'h00);
    io_write(8'hEB, 8'hFF);
    io_read(8'hEB, d);
    check(d == 8'h00, "R11 bad index reads zero", 32'(d), 32'h0);
    check(pad_out == snap, "R11 bad index write ignored", 32'(pad_out), 32'(snap));
  endtask

  task automatic t_disable_again();
    logic [7:0] d;
    cfg_write(8'h03, 8'h03);
    io_read(8'hEA, d);
    check(d == 8'hFF, "R3 disabled again", 32'(d), 32'hFF);
    io_write(8'hEA, 8'h01);
    cfg_write(8'h03, 8'h83);
    io_read(8'hEA, d);
    check(d == 8'h00, "R3 write while disabled ignored", 32'(d), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled_write();
    t_select();
    t_data_rmw();
    t_group_b();
    t_input_read();
    t_polarity_out();
    t_special();
    t_cfg_addr();
    t_bad_index();
    t_disable_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule